// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer on a 32-bit register bus that takes only whole-word accesses. A single-cycle tick input, synchronous to the bus clock, advances a 31-bit counter while either of two enable bits in the configuration register is set. A view of the counter, shifted right by a programmable amount and cut to 16 bits, is compared every cycle against a 16-bit threshold. When the view reaches or passes the threshold, a sticky pending bit is set and drives the interrupt line. Optionally the counter is cleared, and optionally a one-cycle reset-request pulse is raised.

Software can change nothing except the key register without first writing a magic key value there. The unlock is single-use: the next write to any protected register spends it, whether or not that write has any effect. A feed write clears the counter only when it carries the magic feed value. Both magic values are module parameters.

Register offsets (software-visible): configuration 0x00, counter 0x08, scaled view 0x10 (read only), feed 0x18, key 0x1C, threshold 0x20. Configuration bits: [3:0] shift amount, 8 reset-request enable, 9 clear-on-match, 12 run-always enable, 13 run-while-awake enable, 28 pending. The other bits are not stored and read as zero.

Top module: `keylock_wdog`

## Requirements
- R1: After reset, the configuration register reads 0, the counter reads 0, the threshold reads 0xBEEF, the key register reads 0, and irq and rst_req are low.
- R2: Writing KEY_VAL to offset 0x1C sets the unlock flag, which the key register returns in bit 0. Writing any other value there changes nothing.
- R3: While the unlock flag is clear, writes to offsets 0x00, 0x08, 0x18 and 0x20 change no state.
- R4: A write to 0x00, 0x08, 0x18 or 0x20 made while unlocked clears the unlock flag, even a feed write with the wrong value. Writes to 0x10 and to undefined offsets neither change state nor clear the flag.
- R5: The counter is 31 bits wide. A write loads wdata[30:0] and bit 31 always reads 0. The counter adds one on each cycle with tick high while bit 12 or bit 13 is set, holds otherwise, and wraps from 0x7FFFFFFF to 0.
- R6: Offset 0x10 reads the counter shifted right by configuration bits [3:0], truncated to its low 16 bits.
- R7: A feed write of FEED_VAL to 0x18 clears the counter. Any other feed value leaves it unchanged. Offset 0x18 reads 0.
- R8: When the scaled view is greater than or equal to the threshold, bit 28 is set on the next clock edge. irq equals bit 28.
- R9: Bit 28 stays set until a configuration write with bit 28 clear, made while the compare condition is false, clears it.
- R10: With bit 9 set, a true compare condition clears the counter on the next clock edge. With bit 9 clear, the counter is left alone.
- R11: With bit 8 set, rst_req is high for exactly the first cycle in which the compare condition is true, and it does not repeat while the condition stays true. With bit 8 clear, rst_req stays low.
- R12: Reads of undefined or non-word-aligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick | input | 1 | Single-cycle count enable from the slow time base |
| irq | output | 1 | Interrupt, follows the pending bit |
| rst_req | output | 1 | One-cycle reset-request pulse |

## Verification
The scaled view is tried with a table of shift amounts and counter values: zero shift with bits above 15 set, which shows truncation; the largest shift on a full counter; and middle shifts that show where the field boundary falls. The key gate is tried with wrong keys, right keys, and writes to every protected, read-only and undefined offset, which separates a write that spends the unlock from one that does not. The compare path is driven by ticking the counter onto the threshold with the clear-on-match and reset-request bits each on and off, which shows the one-cycle delay of the pending bit, its stickiness, the auto-clear, and the single pulse that is not repeated while the condition persists.

// File: rtl/keylock_wdog_pkg.sv
package keylock_wdog_pkg;

  // Byte offsets seen by software
  localparam int unsigned OFS_CFG   = 32'h00;
  localparam int unsigned OFS_COUNT = 32'h08;
  localparam int unsigned OFS_VIEW  = 32'h10;
  localparam int unsigned OFS_FEED  = 32'h18;
  localparam int unsigned OFS_KEY   = 32'h1C;
  localparam int unsigned OFS_THR   = 32'h20;

  // Configuration bit positions decoded by software
  localparam int unsigned SHIFT_LSB = 0;
  localparam int unsigned SHIFT_W   = 4;
  localparam int unsigned B_RSTEN   = 8;
  localparam int unsigned B_ZCLR    = 9;
  localparam int unsigned B_RUNALW  = 12;
  localparam int unsigned B_RUNAWK  = 13;
  localparam int unsigned B_PEND    = 28;

  typedef struct packed {
    logic               pend;
    logic               run_awake;
    logic               run_always;
    logic               zero_clr;
    logic               rst_en;
    logic [SHIFT_W-1:0] shift;
  } wd_cfg_t;

  function automatic logic [31:0] cfg_to_word(wd_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[SHIFT_LSB +: SHIFT_W] = c.shift;
    w[B_RSTEN]  = c.rst_en;
    w[B_ZCLR]   = c.zero_clr;
    w[B_RUNALW] = c.run_always;
    w[B_RUNAWK] = c.run_awake;
    w[B_PEND]   = c.pend;
    return w;
  endfunction

  function automatic wd_cfg_t word_to_cfg(logic [31:0] w);
    wd_cfg_t c;
    c.shift      = w[SHIFT_LSB +: SHIFT_W];
    c.rst_en     = w[B_RSTEN];
    c.zero_clr   = w[B_ZCLR];
    c.run_always = w[B_RUNALW];
    c.run_awake  = w[B_RUNAWK];
    c.pend       = w[B_PEND];
    return c;
  endfunction

endpackage

// File: rtl/kw_keygate.sv
module kw_keygate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,      // correct key written
  input  logic spend,    // write to a protected register
  output logic unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     unlocked <= 1'b0;
    else if (arm)   unlocked <= 1'b1;
    else if (spend) unlocked <= 1'b0;
  end
endmodule

// File: rtl/kw_counter.sv
module kw_counter #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= load_val;
    else if (clear)  count <= '0;
    else if (step)   count <= count + 1'b1;
  end
endmodule

// File: rtl/kw_compare.sv
module kw_compare #(
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned CMP_W   = 16,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic [CNT_W-1:0]   count,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [CMP_W-1:0]   threshold,
  output logic [CMP_W-1:0]   view,
  output logic               hit
);
  function automatic logic [CMP_W-1:0] scale_down(logic [CNT_W-1:0] c,
                                                  logic [SHIFT_W-1:0] s);
    logic [CNT_W-1:0] t;
    t = c >> s;
    return t[CMP_W-1:0];
  endfunction

  assign view = scale_down(count, shift);
  assign hit  = (view >= threshold);
endmodule

// File: rtl/keylock_wdog.sv
module keylock_wdog
  import keylock_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CNT_W    = 31,
  parameter int unsigned CMP_W    = 16,
  parameter logic [31:0] KEY_VAL  = 32'h51F1_5EED,
  parameter logic [31:0] FEED_VAL = 32'h0D09_F00D,
  parameter logic [CMP_W-1:0] THR_INIT = CMP_W'(16'hBEEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_VIEW  = ADDR_W'(OFS_VIEW);
  localparam logic [ADDR_W-1:0] A_FEED  = ADDR_W'(OFS_FEED);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);
  localparam logic [ADDR_W-1:0] A_THR   = ADDR_W'(OFS_THR);

  // Decode
  logic wr, sel_cfg, sel_cnt, sel_feed, sel_key, sel_thr;
  assign wr       = bus_en & bus_we;
  assign sel_cfg  = (bus_addr == A_CFG);
  assign sel_cnt  = (bus_addr == A_COUNT);
  assign sel_feed = (bus_addr == A_FEED);
  assign sel_key  = (bus_addr == A_KEY);
  assign sel_thr  = (bus_addr == A_THR);

  // Named events for the checker
  logic key_arm, guard_wr, unlocked, taken;
  logic cfg_wr, cnt_load, feed_ok, thr_wr, thr_try;
  logic cmp_hit, zero_on_hit, hit_prev;

  assign key_arm  = wr & sel_key & (bus_wdata == KEY_VAL);
  assign guard_wr = wr & (sel_cfg | sel_cnt | sel_feed | sel_thr);
  assign taken    = guard_wr & unlocked;
  assign cfg_wr   = taken & sel_cfg;
  assign cnt_load = taken & sel_cnt;
  assign feed_ok  = taken & sel_feed & (bus_wdata == FEED_VAL);
  assign thr_wr   = taken & sel_thr;
  assign thr_try  = wr & sel_thr;

  kw_keygate u_gate (
    .clk(clk), .rst_n(rst_n), .arm(key_arm), .spend(guard_wr), .unlocked(unlocked)
  );

  // Configuration and threshold registers
  wd_cfg_t cfg_q, cfg_nx;
  logic [CMP_W-1:0] thr_q;

  always_comb begin
    cfg_nx = cfg_q;
    if (cfg_wr) cfg_nx = word_to_cfg(bus_wdata);
    cfg_nx.pend = cfg_nx.pend | cmp_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      thr_q    <= THR_INIT;
      hit_prev <= 1'b0;
    end else begin
      cfg_q    <= cfg_nx;
      hit_prev <= cmp_hit;
      if (thr_wr) thr_q <= bus_wdata[CMP_W-1:0];
    end
  end

  // Counter and comparator
  logic [CNT_W-1:0] count;
  logic [CMP_W-1:0] view;
  logic             running;

  assign running     = cfg_q.run_always | cfg_q.run_awake;
  assign zero_on_hit = cmp_hit & cfg_q.zero_clr;

  kw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(cnt_load), .load_val(bus_wdata[CNT_W-1:0]),
    .clear(feed_ok | zero_on_hit), .step(tick & running),
    .count(count)
  );

  kw_compare #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SHIFT_W(SHIFT_W)) u_cmp (
    .count(count), .shift(cfg_q.shift), .threshold(thr_q),
    .view(view), .hit(cmp_hit)
  );

  assign irq     = cfg_q.pend;
  assign rst_req = cmp_hit & ~hit_prev & cfg_q.rst_en;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (sel_cfg)      bus_rdata = cfg_to_word(cfg_q);
    else if (sel_cnt) bus_rdata = 32'(count);
    else if (bus_addr == A_VIEW) bus_rdata = 32'(view);
    else if (sel_key) bus_rdata = 32'(unlocked);
    else if (sel_thr) bus_rdata = 32'(thr_q);
  end
endmodule

// File: rtl/keylock_wdog_chk.sv
module keylock_wdog_chk #(
  parameter int unsigned CNT_W = 31,
  parameter int unsigned CMP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit,
  input logic             zero_on_hit,
  input logic             cnt_load,
  input logic             unlocked,
  input logic             guard_wr,
  input logic             cfg_wr,
  input logic             thr_try,
  input logic             irq,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CMP_W-1:0] thr_val
);
  AST_PEND_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cfg_wr |=> irq); // R9
  AST_ZERO_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    zero_on_hit && !cnt_load |=> cnt_val == '0); // R10
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R11
  AST_LOCKED_THR: assert property (@(posedge clk) disable iff (!rst_n)
    thr_try && !unlocked |=> $stable(thr_val)); // R3
  AST_UNLOCK_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    guard_wr && unlocked |=> !unlocked); // R4
endmodule

bind keylock_wdog keylock_wdog_chk #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(cmp_hit), .zero_on_hit(zero_on_hit),
  .cnt_load(cnt_load), .unlocked(unlocked), .guard_wr(guard_wr),
  .cfg_wr(cfg_wr), .thr_try(thr_try), .irq(irq), .rst_req(rst_req),
  .cnt_val(count), .thr_val(thr_q)
);

// File: tb/keylock_wdog_bench.sv
`timescale 1ns/1ps
module keylock_wdog_bench;
  localparam logic [31:0] KEY  = 32'h51F1_5EED;
  localparam logic [31:0] FEED = 32'h0D09_F00D;
  localparam logic [5:0] O_CFG = 6'h00, O_CNT = 6'h08, O_VIEW = 6'h10,
                         O_FEED = 6'h18, O_KEY = 6'h1C, O_THR = 6'h20;

  // {shift, counter value, expected scaled view}
  localparam int NV = 7;
  localparam logic [51:0] VECS [NV] = '{
    {4'd0,  32'h0000_0005, 16'h0005},
    {4'd0,  32'h0001_0005, 16'h0005},
    {4'd4,  32'h0000_1230, 16'h0123},
    {4'd15, 32'h7FFF_FFFF, 16'hFFFF},
    {4'd8,  32'h00AB_CD12, 16'hABCD},
    {4'd3,  32'h0000_000F, 16'h0001},
    {4'd15, 32'h0000_7FFF, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, tick = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, rst_req;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keylock_wdog #(.KEY_VAL(KEY), .FEED_VAL(FEED)) u_keylock_wdog (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic kwr(input logic [5:0] a, input logic [31:0] d);
    wr(O_KEY, KEY);
    wr(a, d);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick_n(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset_state();
    logic [31:0] v;
    rd(O_CFG, v);  check("R1 cfg", v, 32'h0);
    rd(O_CNT, v);  check("R1 count", v, 32'h0);
    rd(O_THR, v);  check("R1 threshold", v, 32'h0000_BEEF);
    rd(O_KEY, v);  check("R1 key", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    check_reset_state();

    // Scaled-view table (R6)
    for (int i = 0; i < NV; i++) begin
      kwr(O_CFG, {28'b0, VECS[i][51:48]});
      kwr(O_CNT, VECS[i][47:16]);
      rd(O_VIEW, v);
      check($sformatf("R6 view vector %0d", i), v, {16'b0, VECS[i][15:0]});
    end

    do_reset();
    check_reset_state();

    // Locked writes ignored (R3)
    wr(O_THR, 32'h1234); rd(O_THR, v); check("R3 locked threshold", v, 32'hBEEF);
    wr(O_CNT, 32'h55);   rd(O_CNT, v); check("R3 locked count", v, 32'h0);
    wr(O_CFG, 32'h1000); rd(O_CFG, v); check("R3 locked cfg", v, 32'h0);

    // Key behaviour (R2)
    wr(O_KEY, 32'h0);    rd(O_KEY, v); check("R2 wrong key", v, 32'h0);
    wr(O_KEY, KEY);      rd(O_KEY, v); check("R2 right key", v, 32'h1);
    wr(O_KEY, 32'h123);  rd(O_KEY, v); check("R2 other value keeps", v, 32'h1);

    // Non-protected offsets do not spend the unlock (R4), undefined reads (R12)
    wr(O_VIEW, 32'h5);   rd(O_KEY, v); check("R4 view write keeps unlock", v, 32'h1);
    rd(O_CNT, v);        check("R4 view write no effect", v, 32'h0);
    wr(6'h24, 32'hFFFF); rd(O_KEY, v); check("R4 undefined write keeps unlock", v, 32'h1);
    rd(6'h24, v);        check("R12 undefined read", v, 32'h0);
    rd(6'h02, v);        check("R12 misaligned read", v, 32'h0);
    rd(O_FEED, v);       check("R7 feed reads zero", v, 32'h0);

    // Load spends unlock (R5, R4)
    wr(O_CNT, 32'h77);   rd(O_CNT, v); check("R5 count load", v, 32'h77);
    rd(O_KEY, v);        check("R4 load spends unlock", v, 32'h0);

    // Feed (R7, R4)
    kwr(O_FEED, 32'h1);  rd(O_CNT, v); check("R7 wrong feed keeps count", v, 32'h77);
    rd(O_KEY, v);        check("R4 wrong feed spends unlock", v, 32'h0);
    kwr(O_FEED, FEED);   rd(O_CNT, v); check("R7 feed clears count", v, 32'h0);

    // Width, bit 31 and wrap (R5)
    kwr(O_THR, 32'hFFFF); rd(O_THR, v); check("R3 unlocked threshold write", v, 32'hFFFF);
    kwr(O_CNT, 32'hFFFF_FFFE); rd(O_CNT, v); check("R5 bit31 cleared", v, 32'h7FFF_FFFE);
    kwr(O_CFG, 32'h1000); tick_n(2);
    rd(O_CNT, v);        check("R5 wrap to zero", v, 32'h0);

    // Disabled holds, awake enable counts (R5, R9)
    kwr(O_CFG, 32'h0);   rd(O_CFG, v); check("R9 cfg write clears pend", v, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    tick_n(5);           rd(O_CNT, v); check("R5 hold when disabled", v, 32'h0);
    kwr(O_CFG, 32'h2000); tick_n(5);
    rd(O_CNT, v);        check("R5 awake enable counts", v, 32'h5);

    // Compare sets pending one edge later (R8, R11 off)
    kwr(O_THR, 32'h8); tick_n(3);
    rd(O_CNT, v);        check("R5 count at threshold", v, 32'h8);
    check("R8 irq not yet", {31'b0, irq}, 32'h0);
    check("R11 no pulse when disabled", {31'b0, rst_req}, 32'h0);
    @(negedge clk);
    check("R8 irq set", {31'b0, irq}, 32'h1);
    rd(O_CFG, v);        check("R8 pend bit28", v, 32'h1000_2000);
    rd(O_VIEW, v);       check("R6 view at hit", v, 32'h8);

    // Sticky (R9)
    kwr(O_THR, 32'hFFFF);
    check("R9 pend sticky", {31'b0, irq}, 32'h1);
    kwr(O_CFG, 32'h2000);
    check("R9 pend cleared", {31'b0, irq}, 32'h0);

    // Reset pulse with clear-on-match (R10, R11)
    kwr(O_CFG, 32'h2300); kwr(O_THR, 32'hA); tick_n(2);
    check("R11 pulse on first hit", {31'b0, rst_req}, 32'h1);
    @(negedge clk);
    check("R11 pulse one cycle", {31'b0, rst_req}, 32'h0);
    rd(O_CNT, v);        check("R10 clear on match", v, 32'h0);
    check("R8 irq after auto clear", {31'b0, irq}, 32'h1);

    // Pulse not repeated while hit persists, no clear without bit9 (R11, R10)
    kwr(O_CFG, 32'h2100);
    check("R9 irq cleared again", {31'b0, irq}, 32'h0);
    kwr(O_CNT, 32'h20);
    check("R11 pulse on load hit", {31'b0, rst_req}, 32'h1);
    @(negedge clk);
    check("R11 no repeat while hit", {31'b0, rst_req}, 32'h0);
    @(negedge clk);
    check("R11 still no repeat", {31'b0, rst_req}, 32'h0);
    rd(O_CNT, v);        check("R10 no clear when bit9 off", v, 32'h20);
    check("R8 irq on load hit", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule